// File: doc/BRIEF.md
# SPI Controller Interrupt Aggregator

This block builds the interrupt status word of an SPI controller whose transmit and receive paths each have a byte-wide FIFO. It takes the FIFO occupancy counts, the two full flags, and one-cycle pulses for three error events: transmit underflow, receive overflow and mode fault. From these it keeps a seven-bit status word and a seven-bit enable mask. It drives one interrupt line that is high whenever an enabled status bit is set.

Three of the status bits are sticky event flags. They stay set until software clears them. The other four are level bits, rebuilt every cycle from FIFO state and two programmable thresholds. Software reaches the block through a small register port with a valid, write, word-address and data interface, and reads return one cycle later. Reading the status word clears its sticky flags, and so does writing ones to it. The mask has separate set and clear registers. While the controller runs in its linear memory-mapped mode, the whole status word is held.

Top module: `spi_irq_aggregator`

## Requirements
- R1: Status bit positions are: 0 receive overflow, 1 mode fault, 2 transmit count below its threshold, 3 transmit FIFO full, 4 receive count at or above its threshold, 5 receive FIFO full, 6 transmit underflow. Status reads return zero in bits 31..7.
- R2: A pulse on an event input sets its sticky bit (0, 1 or 6) at the next clock edge, and the bit then stays set until it is cleared. If an event and a clear of that bit arrive in the same cycle, the event wins.
- R3: Level bits 2 to 5 follow the FIFO inputs one cycle later: bit 2 = tx_count < tx threshold, bit 3 = tx_full, bit 4 = rx_count >= rx threshold, bit 5 = rx_full. A clear of a level bit has no effect while its condition holds.
- R4: Writing to address 0 clears each sticky bit whose data bit is one.
- R5: Reading address 0 returns the status word and clears all sticky bits at that edge.
- R6: Writing to address 1 sets the mask bits given by data ones. Writing to address 2 clears them. Both addresses read as zero.
- R7: Address 3 returns the mask. Writes to address 3 leave the mask unchanged.
- R8: irq is high exactly when some bit is set in both the mask and the status word, and it follows their registered values.
- R9: Address 4 holds the transmit threshold and address 5 the receive threshold. Each is CNT_W bits wide, readable and writable.
- R10: Synchronous reset clears the status word and the mask, drives irq low, and sets both thresholds to 1.
- R11: While linear_mode is high, the status word is held entirely. Events, write clears and read clears are all ignored.
- R12: An accepted read raises rvalid for one cycle on the next edge, with rdata. Writes give no rvalid. Unmapped addresses 6 and 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| tx_underflow_evt | input | 1 | One-cycle transmit underflow pulse |
| rx_overflow_evt | input | 1 | One-cycle receive overflow pulse |
| mode_fault_evt | input | 1 | One-cycle mode fault pulse |
| linear_mode | input | 1 | Linear memory-mapped mode, holds the status word |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read response strobe |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CNT_W = 6 and DATA_W = 32. A six-bit count reaches the occupancy of a 32-entry FIFO, and both thresholds can be set to 0 or 63. With threshold 0, the transmit bit can never rise and the receive bit is always set. With threshold 63, nearly every count sits below it, so both compare directions are exercised at their limits. The width of 32 shows that the unused upper read bits stay zero.

// File: rtl/spi_irq_pkg.sv
// Package: shared constants and register selectors for the SPI interrupt aggregator.
// Assumes a 3-bit word address and a seven-bit status word.
package spi_irq_pkg;
    localparam int NUM_IRQ    = 7;
    localparam int REG_ADDR_W = 3;

    localparam int BIT_RX_OVF   = 0;
    localparam int BIT_MODE_ERR = 1;
    localparam int BIT_TX_LOW   = 2;
    localparam int BIT_TX_FULL  = 3;
    localparam int BIT_RX_AVAIL = 4;
    localparam int BIT_RX_FULL  = 5;
    localparam int BIT_TX_UNF   = 6;

    // Bits that latch events; the remainder are rebuilt each cycle.
    localparam logic [NUM_IRQ-1:0] STICKY_BITS = 7'b100_0011;

    typedef enum logic [REG_ADDR_W-1:0] {
        SEL_STATUS  = 3'd0,
        SEL_ENABLE  = 3'd1,
        SEL_DISABLE = 3'd2,
        SEL_MASK    = 3'd3,
        SEL_TX_THR  = 3'd4,
        SEL_RX_THR  = 3'd5
    } reg_sel_e;
endpackage

// File: rtl/spi_irq_regport.sv
// Register port: decodes accesses into clear/set strobes, keeps the two
// thresholds and returns read data one cycle after a read is accepted.
// Assumes every request is accepted in the cycle it is presented.
module spi_irq_regport
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    input  logic [NUM_IRQ-1:0]    status_q,
    input  logic [NUM_IRQ-1:0]    mask_q,
    output logic [NUM_IRQ-1:0]    status_w1c,
    output logic                  status_rd_clr,
    output logic [NUM_IRQ-1:0]    mask_set,
    output logic [NUM_IRQ-1:0]    mask_clr,
    output logic [CNT_W-1:0]      tx_thr,
    output logic [CNT_W-1:0]      rx_thr,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid
);
    logic                  wr_acc;
    logic                  rd_acc;
    logic [DATA_W-1:0]     rdata_nxt;
    logic                  unused_wdata;

    assign wr_acc = reg_valid & reg_write;
    assign rd_acc = reg_valid & ~reg_write;
    assign unused_wdata = ^reg_wdata;

    // Decode write strobes for status clear and mask set/clear.
    always_comb begin
        status_w1c    = '0;
        mask_set      = '0;
        mask_clr      = '0;
        status_rd_clr = rd_acc && (reg_addr == SEL_STATUS);
        if (wr_acc) begin
            case (reg_sel_e'(reg_addr))
                SEL_STATUS:  status_w1c = reg_wdata[NUM_IRQ-1:0];
                SEL_ENABLE:  mask_set   = reg_wdata[NUM_IRQ-1:0];
                SEL_DISABLE: mask_clr   = reg_wdata[NUM_IRQ-1:0];
                default:     ;
            endcase
        end
    end

    // Threshold registers, reset to one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_thr <= CNT_W'(1);
            rx_thr <= CNT_W'(1);
        end else if (wr_acc) begin
            if (reg_addr == SEL_TX_THR) tx_thr <= reg_wdata[CNT_W-1:0];
            if (reg_addr == SEL_RX_THR) rx_thr <= reg_wdata[CNT_W-1:0];
        end
    end

    // Read multiplexer; set/clear registers and unmapped words read zero.
    always_comb begin
        case (reg_sel_e'(reg_addr))
            SEL_STATUS: rdata_nxt = DATA_W'(status_q);
            SEL_MASK:   rdata_nxt = DATA_W'(mask_q);
            SEL_TX_THR: rdata_nxt = DATA_W'(tx_thr);
            SEL_RX_THR: rdata_nxt = DATA_W'(rx_thr);
            default:    rdata_nxt = '0;
        endcase
    end

    // Registered read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= rd_acc;
            if (rd_acc) reg_rdata <= rdata_nxt;
        end
    end
endmodule

// File: rtl/spi_irq_status.sv
// Status word: per bit either a sticky event latch or a level flag rebuilt
// from FIFO state every cycle. Holds everything while freeze is high.
// Assumes event inputs are single-cycle pulses.
module spi_irq_status
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               freeze,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic [CNT_W-1:0]   tx_thr,
    input  logic [CNT_W-1:0]   rx_thr,
    input  logic               tx_full,
    input  logic               rx_full,
    input  logic [NUM_IRQ-1:0] evt,
    input  logic [NUM_IRQ-1:0] status_w1c,
    input  logic               status_rd_clr,
    output logic [NUM_IRQ-1:0] status_q
);
    logic [NUM_IRQ-1:0] level;

    // Live FIFO conditions at their status positions.
    always_comb begin
        level               = '0;
        level[BIT_TX_LOW]   = tx_count < tx_thr;
        level[BIT_TX_FULL]  = tx_full;
        level[BIT_RX_AVAIL] = rx_count >= rx_thr;
        level[BIT_RX_FULL]  = rx_full;
    end

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_bit
        if (STICKY_BITS[i]) begin : g_sticky
            // Event latch: the event wins over a clear in the same cycle.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[i] <= 1'b0;
                else if (!freeze)
                    status_q[i] <= (status_q[i] & ~(status_w1c[i] | status_rd_clr)) | evt[i];
            end
        end else begin : g_level
            // Level flag: re-derived each cycle, so clears cannot remove it.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status_q[i] <= 1'b0;
                else if (!freeze)
                    status_q[i] <= level[i];
            end
        end
    end
endmodule

// File: rtl/spi_irq_mask.sv
// Interrupt enable mask built from separate set and clear strobes.
// Assumes set and clear never target the same bit in one cycle.
module spi_irq_mask
    import spi_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] mask_set,
    input  logic [NUM_IRQ-1:0] mask_clr,
    output logic [NUM_IRQ-1:0] mask_q
);
    // Apply set and clear strobes to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= (mask_q | mask_set) & ~mask_clr;
    end
endmodule

// File: rtl/spi_irq_aggregator.sv
// Top level: gathers FIFO state and error pulses into a status word, keeps
// the enable mask and drives one interrupt line from their AND.
// Assumes FIFO inputs are synchronous to clk.
module spi_irq_aggregator
    import spi_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      tx_count,
    input  logic [CNT_W-1:0]      rx_count,
    input  logic                  tx_full,
    input  logic                  rx_full,
    input  logic                  tx_underflow_evt,
    input  logic                  rx_overflow_evt,
    input  logic                  mode_fault_evt,
    input  logic                  linear_mode,
    input  logic                  reg_valid,
    input  logic                  reg_write,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    output logic                  reg_rvalid,
    output logic                  irq
);
    logic [NUM_IRQ-1:0] status_q;
    logic [NUM_IRQ-1:0] mask_q;
    logic [NUM_IRQ-1:0] status_w1c;
    logic               status_rd_clr;
    logic [NUM_IRQ-1:0] mask_set;
    logic [NUM_IRQ-1:0] mask_clr;
    logic [CNT_W-1:0]   tx_thr;
    logic [CNT_W-1:0]   rx_thr;
    logic [NUM_IRQ-1:0] evt;

    // Place event pulses at their status positions.
    always_comb begin
        evt               = '0;
        evt[BIT_RX_OVF]   = rx_overflow_evt;
        evt[BIT_MODE_ERR] = mode_fault_evt;
        evt[BIT_TX_UNF]   = tx_underflow_evt;
    end

    spi_irq_regport #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regport (
        .clk(clk), .rst_n(rst_n),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .status_q(status_q), .mask_q(mask_q),
        .status_w1c(status_w1c), .status_rd_clr(status_rd_clr),
        .mask_set(mask_set), .mask_clr(mask_clr),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid)
    );

    spi_irq_status #(.CNT_W(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .freeze(linear_mode),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_thr(tx_thr), .rx_thr(rx_thr),
        .tx_full(tx_full), .rx_full(rx_full), .evt(evt),
        .status_w1c(status_w1c), .status_rd_clr(status_rd_clr),
        .status_q(status_q)
    );

    spi_irq_mask u_mask (
        .clk(clk), .rst_n(rst_n),
        .mask_set(mask_set), .mask_clr(mask_clr), .mask_q(mask_q)
    );

    // Interrupt line from the registered mask and status.
    assign irq = |(mask_q & status_q);
endmodule

// File: rtl/spi_irq_aggregator_chk.sv
// Checker: temporal properties of the aggregator, bound to the top module.
module spi_irq_aggregator_chk
    import spi_irq_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  linear_mode,
    input logic                  tx_underflow_evt,
    input logic                  reg_valid,
    input logic                  reg_write,
    input logic [REG_ADDR_W-1:0] reg_addr,
    input logic [NUM_IRQ-1:0]    wdata_lo,
    input logic [NUM_IRQ-1:0]    status_q,
    input logic [NUM_IRQ-1:0]    mask_q,
    input logic                  reg_rvalid,
    input logic                  irq
);
    assert_underflow_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!linear_mode && tx_underflow_evt) |=> status_q[BIT_TX_UNF]);

    assert_sticky_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!linear_mode && status_q[BIT_RX_OVF] && !(reg_valid && reg_addr == SEL_STATUS))
        |=> status_q[BIT_RX_OVF]);

    assert_enable_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == SEL_ENABLE)
        |=> ((mask_q & $past(wdata_lo)) == $past(wdata_lo)));

    assert_disable_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && reg_write && reg_addr == SEL_DISABLE)
        |=> ((mask_q & $past(wdata_lo)) == '0));

    assert_mask_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && reg_write && (reg_addr == SEL_ENABLE || reg_addr == SEL_DISABLE))
        |=> $stable(mask_q));

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_q != '0 && status_q != '0));

    assert_reset_values_R10: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && mask_q == '0));

    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        linear_mode |=> $stable(status_q));

    assert_read_response_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write) |=> reg_rvalid);

    assert_no_spurious_rvalid_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_valid && !reg_write) |=> !reg_rvalid);
endmodule

bind spi_irq_aggregator spi_irq_aggregator_chk u_chk (
    .clk(clk), .rst_n(rst_n), .linear_mode(linear_mode),
    .tx_underflow_evt(tx_underflow_evt),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .wdata_lo(reg_wdata[spi_irq_pkg::NUM_IRQ-1:0]),
    .status_q(status_q), .mask_q(mask_q),
    .reg_rvalid(reg_rvalid), .irq(irq)
);

// File: tb/test_spi_irq_aggregator.sv
module test_spi_irq_aggregator;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 6;

    typedef struct packed {
        logic [CNT_W-1:0] tthr;
        logic [CNT_W-1:0] rthr;
        logic [CNT_W-1:0] tcnt;
        logic [CNT_W-1:0] rcnt;
        logic             tfull;
        logic             rfull;
        logic [3:0]       exp;   // expected {rx_full, rx_avail, tx_full, tx_low}
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{6'd1,  6'd1,  6'd0,  6'd0,  1'b0, 1'b0, 4'b0001},
        '{6'd1,  6'd1,  6'd5,  6'd3,  1'b0, 1'b0, 4'b0100},
        '{6'd8,  6'd4,  6'd7,  6'd4,  1'b0, 1'b0, 4'b0101},
        '{6'd8,  6'd4,  6'd8,  6'd3,  1'b0, 1'b0, 4'b0000},
        '{6'd0,  6'd0,  6'd0,  6'd0,  1'b0, 1'b0, 4'b0100},
        '{6'd63, 6'd63, 6'd62, 6'd63, 1'b1, 1'b1, 4'b1111},
        '{6'd32, 6'd32, 6'd32, 6'd31, 1'b1, 1'b0, 4'b0010},
        '{6'd2,  6'd2,  6'd1,  6'd2,  1'b0, 1'b1, 4'b1101}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [CNT_W-1:0]  tx_count = '0;
    logic [CNT_W-1:0]  rx_count = '0;
    logic              tx_full = 1'b0;
    logic              rx_full = 1'b0;
    logic              tx_underflow_evt = 1'b0;
    logic              rx_overflow_evt = 1'b0;
    logic              mode_fault_evt = 1'b0;
    logic              linear_mode = 1'b0;
    logic              reg_valid = 1'b0;
    logic              reg_write = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_rvalid;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spi_irq_aggregator #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_spi_irq_aggregator (
        .clk(clk), .rst_n(rst_n),
        .tx_count(tx_count), .rx_count(rx_count),
        .tx_full(tx_full), .rx_full(rx_full),
        .tx_underflow_evt(tx_underflow_evt), .rx_overflow_evt(rx_overflow_evt),
        .mode_fault_evt(mode_fault_evt), .linear_mode(linear_mode),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .irq(irq)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_valid = 1'b0; reg_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [DATA_W-1:0] d);
        @(negedge clk);
        reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
        @(negedge clk);
        reg_valid = 1'b0;
        d = reg_rdata;
        check("R12 rvalid after read", DATA_W'(reg_rvalid), 1);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: rx_overflow_evt = 1'b1;
            1: mode_fault_evt = 1'b1;
            default: tx_underflow_evt = 1'b1;
        endcase
        @(negedge clk);
        rx_overflow_evt = 1'b0; mode_fault_evt = 1'b0; tx_underflow_evt = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [DATA_W-1:0] d;
        idle(3);
        check("R10 irq low in reset", DATA_W'(irq), 0);
        rst_n = 1'b1;
        rd(3'd3, d); check("R10 mask after reset", d, 0);
        rd(3'd4, d); check("R10 R9 tx threshold reset", d, 1);
        rd(3'd5, d); check("R10 R9 rx threshold reset", d, 1);

        // R3 R9 R1: level bits across threshold and count patterns
        for (int i = 0; i < NVEC; i++) begin
            wr(3'd4, DATA_W'(VECS[i].tthr));
            wr(3'd5, DATA_W'(VECS[i].rthr));
            @(negedge clk);
            tx_count = VECS[i].tcnt; rx_count = VECS[i].rcnt;
            tx_full = VECS[i].tfull; rx_full = VECS[i].rfull;
            idle(2);
            rd(3'd0, d);
            check($sformatf("R3 R1 vector %0d", i), d, DATA_W'({1'b0, VECS[i].exp, 2'b00}));
        end
        rd(3'd4, d); check("R9 tx threshold readback", d, 2);

        // quiet baseline: status reads zero
        wr(3'd4, 1); wr(3'd5, 1);
        @(negedge clk);
        tx_count = 6'd5; rx_count = 0; tx_full = 0; rx_full = 0;
        idle(2);
        rd(3'd0, d); check("R3 quiet baseline", d, 0);

        // R2 R5: sticky set, hold, clear on read
        pulse(2);
        idle(5);
        rd(3'd0, d); check("R2 underflow sticky at bit 6", d, 32'h40);
        rd(3'd0, d); check("R5 read clears sticky", d, 0);

        // R4: write-one-to-clear
        pulse(0); pulse(1);
        wr(3'd0, 32'h01);
        rd(3'd0, d); check("R4 selective clear", d, 32'h02);

        // R2: event beats clear in the same cycle
        pulse(1);
        @(negedge clk);
        mode_fault_evt = 1'b1;
        reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 3'd0; reg_wdata = 32'h02;
        @(negedge clk);
        mode_fault_evt = 1'b0; reg_valid = 1'b0; reg_write = 1'b0;
        check("R12 no rvalid after write", DATA_W'(reg_rvalid), 0);
        rd(3'd0, d); check("R2 event wins over clear", d, 32'h02);

        // R3: a clear cannot drop a live level bit
        @(negedge clk); tx_count = 0;
        idle(2);
        wr(3'd0, 32'h04);
        rd(3'd0, d); check("R3 level survives clear", d, 32'h04);

        // R8 R6 R7: mask and interrupt line
        check("R8 irq low with empty mask", DATA_W'(irq), 0);
        wr(3'd1, 32'h04);
        check("R8 irq high when enabled", DATA_W'(irq), 1);
        rd(3'd3, d); check("R6 mask after enable", d, 32'h04);
        rd(3'd1, d); check("R6 enable reads zero", d, 0);
        rd(3'd2, d); check("R6 disable reads zero", d, 0);
        wr(3'd2, 32'h04);
        check("R8 irq low after disable", DATA_W'(irq), 0);
        wr(3'd3, 32'h7F);
        rd(3'd3, d); check("R7 mask write ignored", d, 0);
        check("R7 irq unchanged", DATA_W'(irq), 0);

        // R8: sticky interrupt drops after read clear
        @(negedge clk); tx_count = 6'd5;
        wr(3'd1, 32'h40);
        pulse(2);
        check("R8 irq from sticky bit", DATA_W'(irq), 1);
        rd(3'd0, d);
        check("R8 irq low after read clear", DATA_W'(irq), 0);
        wr(3'd2, 32'h7F);

        // R11: linear mode holds the whole word
        @(negedge clk); tx_count = 0;
        idle(2);
        @(negedge clk); linear_mode = 1'b1;
        pulse(2);
        @(negedge clk); tx_count = 6'd5;
        idle(2);
        rd(3'd0, d); check("R11 frozen during linear mode", d, 32'h04);
        rd(3'd0, d); check("R11 read clear ignored", d, 32'h04);
        @(negedge clk); linear_mode = 1'b0;
        idle(2);
        rd(3'd0, d); check("R11 underflow not latched", d, 0);

        // R12: unmapped words
        rd(3'd6, d); check("R12 unmapped 6 reads zero", d, 0);
        rd(3'd7, d); check("R12 unmapped 7 reads zero", d, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule